// File: doc/BRIEF.md
# Optical Black Clamp Loop Controller

This block is the digital half of an auto-zero calibration loop in an image sensor front end. On each converter clock it takes one converted pixel code per channel. While the shared, active-low optical-black window is open, it compares each code with a fixed black-level target. It turns the signed error into a drive word for an external charge/discharge current DAC. That DAC pushes the offset node of the analog sampler until the black pixels convert to the target code.

The drive strength tracks the error, so the loop converges exponentially when it is close to the target. Beyond a breakpoint the drive is pinned at full current, so a large offset is walked off at a constant slew. Every channel has its own error path, drive register and direction bit. The window strobe, the code valid strobe and the standby pin are common to all channels. Outside the window the drive magnitude is zero, so the hold node keeps its charge.

Code input is a stream with a valid/ready pair. The block never stalls a code it can take: `code_ready` is high whenever standby is low and low whenever standby is high. A code counts as accepted only in a cycle where both `code_valid` and `code_ready` are high. Codes offered while ready is low are dropped, not held, because the converter cannot pause.

Top module: `obc_clamp_ctrl`

## Requirements
- R1: While `rst_n` is low, every `dac_mag` field is 0 and every `dac_dir` bit is 0.
- R2: A code accepted while `clamp_n` is high (window closed) produces drive magnitude 0 and direction 0.
- R3: For an accepted code in the open window, the error is code minus 512. A negative error sets `dac_dir` to 1 (charge), provided the scaled magnitude is nonzero. A positive error, or a zero error, gives `dac_dir` = 0. A zero error gives magnitude 0.
- R4: When the error magnitude e is at most 1543, `dac_mag` = floor(e * 1358 / 2048).
- R5: When the error magnitude e is above 1543, `dac_mag` = 1023.
- R6: At the breakpoint, e = 1543 gives 1023 and e = 1542 gives 1022.
- R7: The drive produced by a code appears at the second rising clock edge after the edge at which the code is accepted. It is still 0 at the first edge.
- R8: In a cycle where `code_valid` is low, the drive two edges later has magnitude 0 and direction 0.
- R9: `code_ready` equals the inverse of `standby`. A rising edge with `standby` high leaves every drive field at 0 just after that edge. While `standby` is high the window strobe has no effect.
- R10: Channel k uses code bits [14k+13:14k] and drives `dac_mag` bits [10k+9:10k] and `dac_dir` bit k. Each channel's drive depends only on its own code, under the shared window, valid and standby inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | High: loop disabled, drive cleared, codes refused |
| clamp_n | input | 1 | Active-low optical-black window, shared by all channels |
| code_valid | input | 1 | A code is present on `code_in` this cycle |
| code_ready | output | 1 | Block accepts a code this cycle |
| code_in | input | NCH*CODE_W (28) | Packed converter codes, channel 0 in the low bits |
| dac_mag | output | NCH*DAC_W (20) | Packed drive magnitudes, channel 0 in the low bits |
| dac_dir | output | NCH (2) | Per-channel direction: 1 charge (raise), 0 discharge |

## Verification
The bench builds the block with its defaults: two channels, 14-bit codes, a 10-bit drive, target 512 and breakpoint 1543. It sweeps every one of the 16384 codes through channel 0 while channel 1 receives the mirrored code. This reaches both sides of the target, the zero-error point, the small errors that scale to zero, the breakpoint pair 1542/1543 and the whole saturated range. A patterned phase then interleaves closed windows, missing valids and standby bursts against a pipeline model, and a single isolated code checks the two-edge latency.

// File: rtl/obc_pkg.sv
package obc_pkg;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } drive_dir_e;

  // Fixed-point gain that maps the breakpoint error onto full-scale drive,
  // rounded to nearest: round(full * 2^sh / brk).
  function automatic int unsigned gain_for(input int unsigned full,
                                           input int unsigned sh,
                                           input int unsigned brk);
    longint unsigned num;
    num = (longint'(full) << sh) + longint'(brk / 2);
    return int'(num / longint'(brk));
  endfunction

  function automatic int unsigned bits_for(input int unsigned v);
    int unsigned n;
    n = 1;
    while ((longint'(1) << n) <= longint'(v)) n++;
    return n;
  endfunction

endpackage

// File: rtl/obc_err_stage.sv
module obc_err_stage #(
  parameter int unsigned CODE_W = 14,
  parameter int unsigned TARGET = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] err_mag,
  output logic              err_below
);

  localparam logic [CODE_W-1:0] TGT_V = CODE_W'(TARGET);

  logic              below_c;
  logic [CODE_W-1:0] mag_c;

  always_comb begin
    below_c = (code < TGT_V);
    if (below_c) mag_c = TGT_V - code;
    else         mag_c = code - TGT_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_mag   <= '0;
      err_below <= 1'b0;
    end else if (clr || !take) begin
      err_mag   <= '0;
      err_below <= 1'b0;
    end else begin
      err_mag   <= mag_c;
      err_below <= below_c;
    end
  end

  // R3
  below_has_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_below |-> (err_mag != '0));

endmodule

// File: rtl/obc_scaler.sv
module obc_scaler
  import obc_pkg::*;
#(
  parameter int unsigned CODE_W = 14,
  parameter int unsigned DAC_W  = 10,
  parameter int unsigned BREAK  = 1543,
  parameter int unsigned SHIFT  = 11
) (
  input  logic [CODE_W-1:0] err_mag,
  input  logic              err_below,
  output logic [DAC_W-1:0]  drv_mag,
  output drive_dir_e        drv_dir
);

  localparam int unsigned FULL   = (1 << DAC_W) - 1;
  localparam int unsigned GAIN   = gain_for(FULL, SHIFT, BREAK);
  localparam int unsigned GAIN_W = bits_for(GAIN);
  localparam int unsigned PROD_W = CODE_W + GAIN_W;

  localparam logic [CODE_W-1:0] BREAK_V = CODE_W'(BREAK);
  localparam logic [PROD_W-1:0] FULL_P  = PROD_W'(FULL);
  localparam logic [DAC_W-1:0]  FULL_V  = DAC_W'(FULL);

  logic [PROD_W-1:0] scaled;
  logic [DAC_W-1:0]  mag_c;

  generate
    if (GAIN == (1 << SHIFT)) begin : g_unity
      assign scaled = PROD_W'(err_mag);
    end else begin : g_mult
      logic [PROD_W-1:0] prod;
      assign prod   = PROD_W'(err_mag) * PROD_W'(GAIN);
      assign scaled = prod >> SHIFT;
    end
  endgenerate

  always_comb begin
    if (err_mag > BREAK_V || scaled > FULL_P) mag_c = FULL_V;
    else                                      mag_c = scaled[DAC_W-1:0];
    drv_mag = mag_c;
    drv_dir = (err_below && mag_c != '0) ? DIR_UP : DIR_DOWN;
  end

endmodule

// File: rtl/obc_drive_reg.sv
module obc_drive_reg
  import obc_pkg::*;
#(
  parameter int unsigned DAC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DAC_W-1:0] mag_d,
  input  drive_dir_e       dir_d,
  output logic [DAC_W-1:0] dac_mag,
  output logic             dac_dir
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_mag <= '0;
      dac_dir <= 1'b0;
    end else if (clr) begin
      dac_mag <= '0;
      dac_dir <= 1'b0;
    end else begin
      dac_mag <= mag_d;
      dac_dir <= (dir_d == DIR_UP);
    end
  end

  // R3
  dir_needs_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_dir |-> (dac_mag != '0));

endmodule

// File: rtl/obc_clamp_ctrl.sv
module obc_clamp_ctrl
  import obc_pkg::*;
#(
  parameter int unsigned NCH    = 2,
  parameter int unsigned CODE_W = 14,
  parameter int unsigned DAC_W  = 10,
  parameter int unsigned TARGET = 512,
  parameter int unsigned BREAK  = 1543,
  parameter int unsigned SHIFT  = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  standby,
  input  logic                  clamp_n,
  input  logic                  code_valid,
  output logic                  code_ready,
  input  logic [NCH*CODE_W-1:0] code_in,
  output logic [NCH*DAC_W-1:0]  dac_mag,
  output logic [NCH-1:0]        dac_dir
);

  logic window;
  logic hit;

  assign code_ready = ~standby;
  assign window     = ~clamp_n & ~standby;
  assign hit        = code_valid & code_ready & window;

  // R9
  stby_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (dac_mag == '0 && dac_dir == '0));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ##1 (dac_mag == '0 && dac_dir == '0));

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic [CODE_W-1:0] code_c;
      logic [CODE_W-1:0] err_mag;
      logic              err_below;
      logic [DAC_W-1:0]  drv_mag;
      drive_dir_e        drv_dir;

      assign code_c = code_in[ch*CODE_W +: CODE_W];

      obc_err_stage #(
        .CODE_W (CODE_W),
        .TARGET (TARGET)
      ) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (standby),
        .take      (hit),
        .code      (code_c),
        .err_mag   (err_mag),
        .err_below (err_below)
      );

      obc_scaler #(
        .CODE_W (CODE_W),
        .DAC_W  (DAC_W),
        .BREAK  (BREAK),
        .SHIFT  (SHIFT)
      ) u_scale (
        .err_mag   (err_mag),
        .err_below (err_below),
        .drv_mag   (drv_mag),
        .drv_dir   (drv_dir)
      );

      obc_drive_reg #(
        .DAC_W (DAC_W)
      ) u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (standby),
        .mag_d   (drv_mag),
        .dir_d   (drv_dir),
        .dac_mag (dac_mag[ch*DAC_W +: DAC_W]),
        .dac_dir (dac_dir[ch])
      );

      // R3
      on_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && code_c == CODE_W'(TARGET)) |=> ##1
          (dac_mag[ch*DAC_W +: DAC_W] == '0 && !dac_dir[ch]));
    end
  endgenerate

endmodule

// File: tb/obc_clamp_ctrl_tb_top.sv
module obc_clamp_ctrl_tb_top;

  localparam int NCH = 2;
  localparam int CW  = 14;
  localparam int DW  = 10;
  localparam int TGT = 512;
  localparam int BRK = 1543;
  localparam int MUL = 1358;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst_n = 1'b0;
  logic                 standby = 1'b0;
  logic                 clamp_n = 1'b1;
  logic                 code_valid = 1'b0;
  logic                 code_ready;
  logic [NCH*CW-1:0]    code_in = '0;
  logic [NCH*DW-1:0]    dac_mag;
  logic [NCH-1:0]       dac_dir;

  obc_clamp_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .standby    (standby),
    .clamp_n    (clamp_n),
    .code_valid (code_valid),
    .code_ready (code_ready),
    .code_in    (code_in),
    .dac_mag    (dac_mag),
    .dac_dir    (dac_dir)
  );

  int vecs = 0;
  int fails = 0;

  int    m_d1[NCH], m_d2[NCH];
  bit    d_d1[NCH], d_d2[NCH];
  string t_d1[NCH], t_d2[NCH];
  bit    sb_d1;

  task automatic check(input string tag, input int ch, input int am, input int em,
                       input int ad, input int ed);
    vecs++;
    if (am != em || ad != ed) begin
      fails++;
      $display("FAIL %s ch%0d: mag=%0d exp %0d dir=%0d exp %0d", tag, ch, am, em, ad, ed);
    end
  endtask

  function automatic void model(input int code, input bit v, input bit cln, input bit sb,
                                input int ch, output int m, output bit d, output string t);
    int e;
    m = 0; d = 0;
    if (sb)       begin t = "R9"; return; end
    if (!v)       begin t = "R8"; return; end
    if (cln)      begin t = "R2"; return; end
    e = (code >= TGT) ? code - TGT : TGT - code;
    if (e > BRK)  begin m = 1023; t = "R5"; end
    else          begin m = (e * MUL) >> 11; t = (e >= 1542) ? "R6" : "R4"; end
    d = (code < TGT) && (m != 0);
    if (e == 0) t = "R3";
    if (ch == 1) t = {t, "/R10"};
  endfunction

  task automatic step(input int c0, input int c1, input bit v, input bit cln, input bit sb);
    int    cc[NCH];
    int    m;
    bit    d;
    string t;
    @(negedge clk);
    for (int ch = 0; ch < NCH; ch++) begin
      if (sb_d1) check("R9", ch, int'(dac_mag[ch*DW +: DW]), 0, int'(dac_dir[ch]), 0);
      else       check(t_d2[ch], ch, int'(dac_mag[ch*DW +: DW]), m_d2[ch],
                       int'(dac_dir[ch]), int'(d_d2[ch]));
    end
    cc[0] = c0; cc[1] = c1;
    code_in    = {CW'(c1), CW'(c0)};
    code_valid = v;
    clamp_n    = cln;
    standby    = sb;
    #1;
    check("R9", 0, int'(code_ready), int'(!sb), 0, 0);
    for (int ch = 0; ch < NCH; ch++) begin
      model(cc[ch], v, cln, sb, ch, m, d, t);
      m_d2[ch] = m_d1[ch]; d_d2[ch] = d_d1[ch]; t_d2[ch] = t_d1[ch];
      m_d1[ch] = m;        d_d1[ch] = d;        t_d1[ch] = t;
    end
    sb_d1 = sb;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    for (int ch = 0; ch < NCH; ch++) begin
      m_d1[ch] = 0; m_d2[ch] = 0; d_d1[ch] = 0; d_d2[ch] = 0;
      t_d1[ch] = "R8"; t_d2[ch] = "R8";
    end
    sb_d1 = 0;

    // R1: reset state, with an active code offered
    code_in = {CW'(0), CW'(CMAX)};
    code_valid = 1'b1;
    clamp_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int ch = 0; ch < NCH; ch++)
      check("R1", ch, int'(dac_mag[ch*DW +: DW]), 0, int'(dac_dir[ch]), 0);
    code_valid = 1'b0;
    clamp_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7: single accepted code, code 0 on ch0 gives 339 charge
    code_in = {CW'(TGT), CW'(0)};
    code_valid = 1'b1;
    clamp_n = 1'b0;
    @(posedge clk);
    #1;
    code_valid = 1'b0;
    clamp_n = 1'b1;
    check("R7", 0, int'(dac_mag[DW-1:0]), 0, int'(dac_dir[0]), 0);
    @(posedge clk);
    #1;
    check("R7", 0, int'(dac_mag[DW-1:0]), 339, int'(dac_dir[0]), 1);
    @(posedge clk);
    #1;
    check("R7", 0, int'(dac_mag[DW-1:0]), 0, int'(dac_dir[0]), 0);
    repeat (2) @(negedge clk);

    // R4 R5 R6 R3 R10: exhaustive sweep, mirrored code on ch1
    for (int c = 0; c <= CMAX; c++) step(c, CMAX - c, 1'b1, 1'b0, 1'b0);

    // R2 R8 R9: interleaved window, valid and standby patterns
    for (int i = 0; i < 3000; i++) begin
      bit v, cln, sb;
      v   = (i % 5) != 0;
      cln = (i % 7) >= 4;
      sb  = ((i % 97) >= 50) && ((i % 97) < 56);
      if ((i % 211) == 3) cln = 1'b0;
      step((i * 37) % (CMAX + 1), (TGT + i * 3) % (CMAX + 1), v, cln, sb);
    end
    for (int i = 0; i < 4; i++) step(0, 0, 1'b0, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule